// File: doc/BRIEF.md
# Peripheral Reset Control Register Bank

This block is a bank of 32-bit reset control registers on a simple word-addressed bus. It sits between software and a cluster made of ten processor cores, two DMA engines and a set of peripherals (two UARTs, two Ethernet MACs, two USB controllers and four CAN controllers). Every register bit that governs a target drives a level output that follows the stored bit. Whenever a write changes that bit, the block also raises a one-cycle strobe toward the target.

Five core-pair registers each govern two cores. Writing 1 to a core bit holds that core powered off. Writing 0 releases it, and the restart strobe tells the core to begin again from reset. Peripheral registers use bit 0 only, and a change in either direction gives that target a reset strobe. Two group registers each fan a single bit out to every channel of one DMA engine. A spare register stores bit 0 and drives nothing. Reads are registered and have no side effects.

Top module: `rst_ctrl_bank`

## Requirements
- R1: A synchronous active-high `rst` loads the following values. Core-pair words read 0x00010303. The DMA group, peripheral and spare words read 0x1, so every level output is 1. No strobe is raised during reset or in the first cycle after it.
- R2: The core-pair register at word k (k = 0..4) drives `core_hold[2k]` from bit 0 and `core_hold[2k+1]` from bit 1. Each level output follows its stored bit from the cycle after the write edge.
- R3: Writing 1 over a stored 0 in a core bit pulses `core_off_stb` for that core. Writing 0 over a stored 1 pulses `core_restart_stb`. Each strobe lasts one cycle, appearing in the cycle after the write edge.
- R4: Rewriting a bit with the value it already holds raises no strobe, for core bits and for single-bit registers alike.
- R5: Only bits 0, 1, 8, 9 and 16 of a core-pair word are writable. All other bits store as zero and read back as zero.
- R6: Each peripheral register uses bit 0 only and drives `per_rst[i]` and `per_stb[i]`. A change of that bit in either direction pulses the strobe for one cycle. The index map is: words 8–9 are UART 0–1 (i = 0–1); words 10–11 are MAC 0–1 (i = 2–3); words 12–13 are USB 0–1 (i = 4–5); words 16–19 are CAN 0–3 (i = 6–9).
- R7: The group register at word 6 drives every channel of `dma_a_rst`/`dma_a_stb` at once. The group register at word 7 drives every channel of `dma_b_rst`/`dma_b_stb` at once. The two engines are independent of each other.
- R8: Spare word 20 stores bit 0 and reads it back. Writing it changes no output and raises no strobe.
- R9: A read returns the stored word on `bus_rdata`, with `bus_rvalid` high, one cycle after `bus_re`. Unmapped words (5, 14, 15 and 21–31) read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_re` |
| core_hold | output | 10 | Per-core hold-off level |
| core_off_stb | output | 10 | Per-core power-off strobe |
| core_restart_stb | output | 10 | Per-core restart strobe |
| per_rst | output | 10 | Peripheral reset levels |
| per_stb | output | 10 | Peripheral reset strobes |
| dma_a_rst | output | DMA_A_CH | First DMA engine reset level, per channel |
| dma_a_stb | output | DMA_A_CH | First DMA engine reset strobe, per channel |
| dma_b_rst | output | DMA_B_CH | Second DMA engine reset level, per channel |
| dma_b_stb | output | DMA_B_CH | Second DMA engine reset strobe, per channel |

## Verification
The bench targets a design that strobes on every write instead of only on a change. Such a design would pulse when the same value is written again. It also checks a core word that routes bit 0 to the wrong core of the pair, or that decodes words off by one, either of which would hold or restart the wrong core. An all-ones write to a core word checks that reserved bits are masked, since a design without masking would read back extra bits. Further cases cover a group register that reaches only some DMA channels, and writes to the spare and unmapped words. Those writes would disturb an output or read back nonzero if decode were too wide.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  localparam int REG_W        = 32;
  localparam int CPU_BASE     = 0;
  localparam int NUM_CPU_REGS = 5;
  localparam int NUM_CORES    = 2 * NUM_CPU_REGS;
  localparam int DMA_A_WORD   = 6;
  localparam int DMA_B_WORD   = 7;
  localparam int UART_BASE    = 8;
  localparam int NUM_UART     = 2;
  localparam int MAC_BASE     = 10;
  localparam int NUM_MAC      = 2;
  localparam int USB_BASE     = 12;
  localparam int NUM_USB      = 2;
  localparam int CAN_BASE     = 16;
  localparam int NUM_CAN      = 4;
  localparam int SPARE_WORD   = 20;
  localparam int NUM_PER      = NUM_UART + NUM_MAC + NUM_USB + NUM_CAN;

  localparam logic [REG_W-1:0] CPU_RST_VAL = 32'h0001_0303;
  localparam logic [REG_W-1:0] CPU_RSVD    = 32'hFFFE_FCFC;

  // Word address of peripheral target i in the flat peripheral index.
  function automatic int per_word(input int i);
    if (i < NUM_UART)                          return UART_BASE + i;
    else if (i < NUM_UART + NUM_MAC)           return MAC_BASE + (i - NUM_UART);
    else if (i < NUM_UART + NUM_MAC + NUM_USB) return USB_BASE + (i - NUM_UART - NUM_MAC);
    else                                       return CAN_BASE + (i - NUM_UART - NUM_MAC - NUM_USB);
  endfunction
endpackage

// File: rtl/rcb_core_pair_reg.sv
module rcb_core_pair_reg #(
  parameter int              W       = 32,
  parameter logic [W-1:0]    RST_VAL = '0,
  parameter logic [W-1:0]    RSVD    = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [1:0]   off_stb,
  output logic [1:0]   on_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= RST_VAL;
      off_stb <= 2'b00;
      on_stb  <= 2'b00;
    end else begin
      off_stb <= we ? (wdata[1:0] & ~q[1:0]) : 2'b00;
      on_stb  <= we ? (~wdata[1:0] & q[1:0]) : 2'b00;
      if (we) q <= wdata & ~RSVD;
    end
  end
endmodule

// File: rtl/rcb_dev_reg.sv
module rcb_dev_reg #(
  parameter int   FANOUT  = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              wbit,
  output logic              q,
  output logic [FANOUT-1:0] lvl,
  output logic [FANOUT-1:0] stb
);
  logic stb_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= RST_VAL;
      stb_r <= 1'b0;
    end else begin
      stb_r <= we && (wbit != q);
      if (we) q <= wbit;
    end
  end

  // One flop per register; replication happens after the flop.
  assign lvl = {FANOUT{q}};
  assign stb = {FANOUT{stb_r}};
endmodule

// File: rtl/rst_ctrl_bank.sv
module rst_ctrl_bank
  import rcb_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DMA_A_CH = 4,
  parameter int DMA_B_CH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_CORES-1:0] core_hold,
  output logic [NUM_CORES-1:0] core_off_stb,
  output logic [NUM_CORES-1:0] core_restart_stb,
  output logic [NUM_PER-1:0]   per_rst,
  output logic [NUM_PER-1:0]   per_stb,
  output logic [DMA_A_CH-1:0]  dma_a_rst,
  output logic [DMA_A_CH-1:0]  dma_a_stb,
  output logic [DMA_B_CH-1:0]  dma_b_rst,
  output logic [DMA_B_CH-1:0]  dma_b_stb
);
  logic [REG_W-1:0] cpu_q [NUM_CPU_REGS];
  logic [NUM_PER-1:0] per_q;
  logic dma_a_q, dma_b_q, spare_q;
  logic [REG_W-1:0] rd_val;

  // Core-pair registers
  for (genvar k = 0; k < NUM_CPU_REGS; k++) begin : g_cpu
    logic we_k;
    assign we_k = bus_we && (bus_addr == ADDR_W'(CPU_BASE + k));
    rcb_core_pair_reg #(.W(REG_W), .RST_VAL(CPU_RST_VAL), .RSVD(CPU_RSVD)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .we      (we_k),
      .wdata   (bus_wdata),
      .q       (cpu_q[k]),
      .off_stb (core_off_stb[2*k +: 2]),
      .on_stb  (core_restart_stb[2*k +: 2])
    );
    assign core_hold[2*k +: 2] = cpu_q[k][1:0];
  end

  // Single-target peripheral registers
  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    logic we_i;
    assign we_i = bus_we && (bus_addr == ADDR_W'(per_word(i)));
    rcb_dev_reg #(.FANOUT(1), .RST_VAL(1'b1)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .we   (we_i),
      .wbit (bus_wdata[0]),
      .q    (per_q[i]),
      .lvl  (per_rst[i +: 1]),
      .stb  (per_stb[i +: 1])
    );
  end

  // DMA group registers
  rcb_dev_reg #(.FANOUT(DMA_A_CH), .RST_VAL(1'b1)) u_dma_a (
    .clk  (clk),
    .rst  (rst),
    .we   (bus_we && (bus_addr == ADDR_W'(DMA_A_WORD))),
    .wbit (bus_wdata[0]),
    .q    (dma_a_q),
    .lvl  (dma_a_rst),
    .stb  (dma_a_stb)
  );

  rcb_dev_reg #(.FANOUT(DMA_B_CH), .RST_VAL(1'b1)) u_dma_b (
    .clk  (clk),
    .rst  (rst),
    .we   (bus_we && (bus_addr == ADDR_W'(DMA_B_WORD))),
    .wbit (bus_wdata[0]),
    .q    (dma_b_q),
    .lvl  (dma_b_rst),
    .stb  (dma_b_stb)
  );

  // Spare storage word: no target
  always_ff @(posedge clk) begin
    if (rst) spare_q <= 1'b1;
    else if (bus_we && (bus_addr == ADDR_W'(SPARE_WORD))) spare_q <= bus_wdata[0];
  end

  // Read decode
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_CPU_REGS; k++)
      if (bus_addr == ADDR_W'(CPU_BASE + k)) rd_val = cpu_q[k];
    for (int i = 0; i < NUM_PER; i++)
      if (bus_addr == ADDR_W'(per_word(i))) rd_val = {{(REG_W-1){1'b0}}, per_q[i]};
    if (bus_addr == ADDR_W'(DMA_A_WORD)) rd_val = {{(REG_W-1){1'b0}}, dma_a_q};
    if (bus_addr == ADDR_W'(DMA_B_WORD)) rd_val = {{(REG_W-1){1'b0}}, dma_b_q};
    if (bus_addr == ADDR_W'(SPARE_WORD)) rd_val = {{(REG_W-1){1'b0}}, spare_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/rst_ctrl_bank_chk.sv
module rst_ctrl_bank_chk #(
  parameter int N_CORE  = 10,
  parameter int N_PER   = 10,
  parameter int N_DMA_A = 4,
  parameter int N_DMA_B = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CORE-1:0]  core_hold,
  input logic [N_CORE-1:0]  core_off_stb,
  input logic [N_CORE-1:0]  core_restart_stb,
  input logic [N_PER-1:0]   per_rst,
  input logic [N_PER-1:0]   per_stb,
  input logic [N_DMA_A-1:0] dma_a_rst,
  input logic [N_DMA_A-1:0] dma_a_stb,
  input logic [N_DMA_B-1:0] dma_b_rst,
  input logic [N_DMA_B-1:0] dma_b_stb
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&core_hold && &per_rst && &dma_a_rst && &dma_b_rst &&
                    core_off_stb == '0 && core_restart_stb == '0 &&
                    per_stb == '0 && dma_a_stb == '0 && dma_b_stb == '0));

  for (genvar j = 0; j < N_CORE; j++) begin : g_core
    p_core_off_r3: assert property (@(posedge clk) disable iff (rst)
      core_off_stb[j] |-> (core_hold[j] && !$past(core_hold[j])));
    p_core_restart_r3: assert property (@(posedge clk) disable iff (rst)
      core_restart_stb[j] |-> (!core_hold[j] && $past(core_hold[j])));
    p_core_change_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && core_hold[j] != $past(core_hold[j])) |->
        (core_off_stb[j] || core_restart_stb[j]));
  end

  for (genvar i = 0; i < N_PER; i++) begin : g_per
    p_per_strobe_r6: assert property (@(posedge clk) disable iff (rst)
      per_stb[i] |-> (per_rst[i] != $past(per_rst[i])));
    p_per_change_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && per_rst[i] != $past(per_rst[i])) |-> per_stb[i]);
  end

  for (genvar c = 0; c < N_DMA_A; c++) begin : g_dma_a
    p_dma_a_strobe_r7: assert property (@(posedge clk) disable iff (rst)
      dma_a_stb[c] |-> (dma_a_rst[c] != $past(dma_a_rst[c])));
  end

  for (genvar c = 0; c < N_DMA_B; c++) begin : g_dma_b
    p_dma_b_strobe_r7: assert property (@(posedge clk) disable iff (rst)
      dma_b_stb[c] |-> (dma_b_rst[c] != $past(dma_b_rst[c])));
  end
endmodule

bind rst_ctrl_bank rst_ctrl_bank_chk #(
  .N_CORE  (rcb_pkg::NUM_CORES),
  .N_PER   (rcb_pkg::NUM_PER),
  .N_DMA_A (DMA_A_CH),
  .N_DMA_B (DMA_B_CH)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .core_hold        (core_hold),
  .core_off_stb     (core_off_stb),
  .core_restart_stb (core_restart_stb),
  .per_rst          (per_rst),
  .per_stb          (per_stb),
  .dma_a_rst        (dma_a_rst),
  .dma_a_stb        (dma_a_stb),
  .dma_b_rst        (dma_b_rst),
  .dma_b_stb        (dma_b_stb)
);

// File: tb/rst_ctrl_bank_tb.sv
`timescale 1ns/1ps
module rst_ctrl_bank_tb;
  localparam int AW = 5;
  localparam int NA = 4;
  localparam int NB = 8;
  localparam int NC = 10;
  localparam int NP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NC-1:0] core_hold, core_off_stb, core_restart_stb;
  logic [NP-1:0] per_rst, per_stb;
  logic [NA-1:0] dma_a_rst, dma_a_stb;
  logic [NB-1:0] dma_b_rst, dma_b_stb;

  always #2.5 clk = ~clk;

  rst_ctrl_bank #(.ADDR_W(AW), .DMA_A_CH(NA), .DMA_B_CH(NB)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .core_hold(core_hold), .core_off_stb(core_off_stb), .core_restart_stb(core_restart_stb),
    .per_rst(per_rst), .per_stb(per_stb), .dma_a_rst(dma_a_rst), .dma_a_stb(dma_a_stb),
    .dma_b_rst(dma_b_rst), .dma_b_stb(dma_b_stb)
  );

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] mdl [32];
  logic [NC-1:0] e_off, e_rs;
  logic [NP-1:0] e_pstb;
  logic [NA-1:0] e_astb;
  logic [NB-1:0] e_bstb;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  // Peripheral index map from R6
  function automatic int pw(input int i);
    if (i < 2) return 8 + i;
    else if (i < 4) return 10 + (i - 2);
    else if (i < 6) return 12 + (i - 4);
    else return 16 + (i - 6);
  endfunction

  function automatic logic [31:0] wmask(input int a);
    if (a < 5) return 32'h0001_0303;
    if (a == 6 || a == 7 || a == 20) return 32'h1;
    for (int i = 0; i < NP; i++) if (a == pw(i)) return 32'h1;
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 32; a++)
      mdl[a] = (a < 5) ? 32'h0001_0303 : wmask(a);
    e_off = '0; e_rs = '0; e_pstb = '0; e_astb = '0; e_bstb = '0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [NC-1:0] eh;
    logic [NP-1:0] ep;
    for (int k = 0; k < 5; k++) begin
      eh[2*k]   = mdl[k][0];
      eh[2*k+1] = mdl[k][1];
    end
    for (int i = 0; i < NP; i++) ep[i] = mdl[pw(i)][0];
    chk({tag, " core_hold"}, 64'(core_hold), 64'(eh));
    chk({tag, " core_off_stb"}, 64'(core_off_stb), 64'(e_off));
    chk({tag, " core_restart_stb"}, 64'(core_restart_stb), 64'(e_rs));
    chk({tag, " per_rst"}, 64'(per_rst), 64'(ep));
    chk({tag, " per_stb"}, 64'(per_stb), 64'(e_pstb));
    chk({tag, " dma_a_rst"}, 64'(dma_a_rst), 64'({NA{mdl[6][0]}}));
    chk({tag, " dma_a_stb"}, 64'(dma_a_stb), 64'(e_astb));
    chk({tag, " dma_b_rst"}, 64'(dma_b_rst), 64'({NB{mdl[7][0]}}));
    chk({tag, " dma_b_stb"}, 64'(dma_b_stb), 64'(e_bstb));
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input string tag);
    @(negedge clk);
    e_off = '0; e_rs = '0; e_pstb = '0; e_astb = '0; e_bstb = '0;
    if (a < 5) begin
      for (int b = 0; b < 2; b++) begin
        e_off[2*a+b] = d[b] & ~mdl[a][b];
        e_rs[2*a+b]  = ~d[b] & mdl[a][b];
      end
    end
    for (int i = 0; i < NP; i++)
      if (a == pw(i) && d[0] != mdl[a][0]) e_pstb[i] = 1'b1;
    if (a == 6 && d[0] != mdl[6][0]) e_astb = '1;
    if (a == 7 && d[0] != mdl[7][0]) e_bstb = '1;
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    mdl[a] = d & wmask(a);
    check_all(tag);
    e_off = '0; e_rs = '0; e_pstb = '0; e_astb = '0; e_bstb = '0;
    @(negedge clk);
    check_all({tag, " strobe cleared"});
  endtask

  task automatic do_read(input int a, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = AW'(a);
    exp_q.push_back(mdl[a]);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (bus_rvalid) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected read data", 64'(bus_rdata), 64'h0);
          n_errors++;
          $display("FAIL R9 rvalid with empty scoreboard actual=%0h expected=none", bus_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, 64'(bus_rdata), 64'(e));
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset state");
    @(negedge clk);
    check_all("R1 first cycle after reset");
    do_read(0, "R1 core word reset value");
    do_read(8, "R1 peripheral word reset value");
    do_read(20, "R1 spare word reset value");

    // Core pairs
    do_write(2, 32'h0001_0302, "R2 R3 restart core 4");
    do_write(2, 32'h0001_0302, "R4 rewrite core word");
    do_write(2, 32'h0001_0303, "R3 power off core 4");
    do_write(1, 32'h0000_0001, "R2 R3 restart core 3 only");
    do_read(1, "R2 core word 1 readback");
    do_write(4, 32'hFFFF_FFFC, "R5 masked write restarts cores 8 9");
    do_read(4, "R5 reserved bits read zero");
    do_write(4, 32'hFFFF_FFFF, "R5 all ones write");
    do_read(4, "R5 all ones readback");
    do_write(0, 32'h0000_0000, "R2 restart cores 0 1");

    // Peripherals
    do_write(9, 32'h0, "R6 UART1 release");
    do_write(9, 32'h0, "R4 UART1 rewrite");
    do_write(19, 32'hFFFF_FFFE, "R6 CAN3 release");
    do_read(19, "R6 CAN3 readback");
    do_write(19, 32'h1, "R6 CAN3 reassert");
    do_write(11, 32'h0, "R6 MAC1 release");
    do_write(12, 32'h0, "R6 USB0 release");
    do_read(11, "R6 MAC1 readback");

    // DMA groups
    do_write(6, 32'h0, "R7 DMA A release");
    do_write(6, 32'h0, "R4 DMA A rewrite");
    do_write(7, 32'h0, "R7 DMA B release");
    do_write(6, 32'h1, "R7 DMA A reassert");
    do_read(7, "R7 DMA B readback");

    // Spare and unmapped
    do_write(20, 32'h0, "R8 spare write");
    do_read(20, "R8 spare readback");
    do_write(5, 32'hFFFF_FFFF, "R9 unmapped write 5");
    do_write(14, 32'hFFFF_FFFF, "R9 unmapped write 14");
    do_read(5, "R9 unmapped read 5");
    do_read(31, "R9 unmapped read 31");

    // Reset from a modified state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_all("R1 reset from modified state");
    do_read(2, "R1 core word after second reset");
    do_read(9, "R1 UART1 after second reset");

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", 64'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule